// File: doc/BRIEF.md
# Cluster-Aware Fast Inter-Processor Interrupt Requester

This block lets any core raise a fast interrupt on another core, either inside its own cluster or anywhere in the system. A requester writes a 32-bit request word through one port. A flag selects between the local register, which addresses a core inside the writer's own cluster, and the global register, which also names a cluster. The word carries a 2-bit delivery kind: immediate, no-wake, deferred or retract. Each core has a pending flag. The flag drives that core's fast-interrupt level until the core writes a 1 to bit 0 of its status word.

Deferred requests are held in a per-core slot. The slot is armed from that core's countdown register and counts down once per cycle. The request becomes pending one cycle after the count reaches zero. A retract cancels a held request before it is delivered. A one-cycle wake pulse comes with every immediate or deferred delivery, but not with a no-wake delivery.

The request port follows valid/ready rules, but the block never applies back-pressure. `req_ready` is high in every cycle, so a request is taken on every clock edge where `req_valid` is high. Clear and countdown writes are plain strobes.

Top module: `fipi_requester`

## Requirements
- R1: During and directly after reset, `fiq` and `wake` are all zero.
- R2: The request word holds the target core in bits [7:0], the target cluster in bits [23:16] and the kind in bits [29:28]. For a global request (`req_global`=1) the target core index is cluster*4+core, with 2 clusters of 4 cores.
- R3: For a local request (`req_global`=0), the cluster is the requester's own cluster (`req_src`/4) and bits [23:16] are ignored.
- R4: Kind 0 (immediate) sets the target's `fiq` bit one cycle after the request is accepted. `wake` for that core pulses in the same cycle. `fiq` then stays high as a level.
- R5: Kind 3 (no-wake) sets the target's `fiq` bit one cycle after acceptance and leaves `wake` low.
- R6: A clear write (`clr_valid`) to a core with `clr_word` bit 0 = 1 drops that core's `fiq` on the next cycle. With bit 0 = 0 it has no effect. A set in the same cycle wins over a clear.
- R7: Kind 2 (deferred) arms the target's slot with the target's countdown value N, written through `cd_wr`. `fiq` and `wake` rise N+1 cycles after the acceptance edge.
- R8: Kind 1 (retract) cancels a held deferred request to the same core, so nothing is delivered. It has no effect on a `fiq` bit that is already set.
- R9: A request whose core field is 4 or more, or whose cluster is 2 or more, is ignored.
- R10: A deferred request to a core whose slot is already held restarts the countdown from the countdown register.
- R11: `req_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_src | input | 3 | Index of the requesting core |
| req_global | input | 1 | 1 = global register, 0 = local register |
| req_word | input | 32 | Request word (core, cluster, kind) |
| clr_valid | input | 1 | Status write strobe |
| clr_core | input | 3 | Core whose status is written |
| clr_word | input | 32 | Status write data; bit 0 = 1 clears pending |
| cd_wr | input | 1 | Countdown register write strobe |
| cd_core | input | 3 | Core whose countdown register is written |
| cd_value | input | 16 | Countdown value |
| fiq | output | 8 | Per-core fast-interrupt level |
| wake | output | 8 | Per-core one-cycle wake pulse |

## Verification
Some properties are checked by assertions on every cycle:
- at most one core is hit per request;
- local requests stay inside the requester's cluster;
- out-of-range requests hit nothing;
- set wins over clear;
- a held slot counts down by one per cycle, and an arm loads the countdown register;
- a retract empties the slot;
- a wake pulse never comes without the level.

The bench scenarios are what show the end-to-end timing:
- the exact N+1 cycle deferred delay;
- the restart on re-arm;
- a retract that arrives mid-count;
- the clear data bit being honoured;
- the no-wake kind staying silent across long random mixes of all four kinds with clears and countdown writes.

// File: rtl/fipi_pkg.sv
package fipi_pkg;

  typedef enum logic [1:0] {
    REQ_NOW   = 2'd0,
    REQ_PULL  = 2'd1,
    REQ_LATER = 2'd2,
    REQ_QUIET = 2'd3
  } req_kind_e;

  // Request word layout; core, cluster and kind positions are decoded.
  typedef struct packed {
    logic [1:0] rsv_top;
    req_kind_e  kind;
    logic [3:0] rsv_mid;
    logic [7:0] cluster;
    logic [7:0] rsv_low;
    logic [7:0] core;
  } req_word_t;

endpackage

// File: rtl/fipi_decode.sv
module fipi_decode
  import fipi_pkg::*;
#(
  parameter int unsigned NCL   = 2,
  parameter int unsigned NCPC  = 4,
  parameter int unsigned NCORE = NCL * NCPC,
  parameter int unsigned SRC_W = $clog2(NCORE)
) (
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic              req_global,
  input  logic [31:0]       req_word,
  output logic [NCORE-1:0]  hit_now,
  output logic [NCORE-1:0]  hit_pull,
  output logic [NCORE-1:0]  hit_later,
  output logic [NCORE-1:0]  hit_quiet
);

  req_word_t  w;
  logic [7:0] tgt_cl;
  logic [15:0] tgt_idx;
  logic       in_range;
  logic [NCORE-1:0] match;

  always_comb begin
    w        = req_word_t'(req_word);
    tgt_cl   = req_global ? w.cluster : 8'(32'(req_src) / NCPC);
    in_range = (32'(w.core) < NCPC) && (32'(tgt_cl) < NCL);
    tgt_idx  = 16'(tgt_cl) * 16'(NCPC) + 16'(w.core);
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    assign match[i]     = req_valid && in_range && (tgt_idx == 16'(i));
    assign hit_now[i]   = match[i] && (w.kind == REQ_NOW);
    assign hit_pull[i]  = match[i] && (w.kind == REQ_PULL);
    assign hit_later[i] = match[i] && (w.kind == REQ_LATER);
    assign hit_quiet[i] = match[i] && (w.kind == REQ_QUIET);
  end

  logic [NCORE-1:0] any_hit;
  logic [NCORE-1:0] own_cl_mask;
  assign any_hit = hit_now | hit_pull | hit_later | hit_quiet;

  always_comb begin
    own_cl_mask = '0;
    for (int c = 0; c < NCORE; c++)
      if (32'(c) / NCPC == 32'(req_src) / NCPC) own_cl_mask[c] = 1'b1;
  end

  // R2: one request reaches at most one core
  always_comb p_single_target_r2: assert ($onehot0(any_hit));
  // R3: a local request never leaves the requester's cluster
  always_comb p_local_cluster_r3: assert (req_global || ((any_hit & ~own_cl_mask) == '0));

endmodule

// File: rtl/fipi_defer_slot.sv
module fipi_defer_slot #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cd_we,
  input  logic [CNT_W-1:0] cd_val,
  input  logic             arm,
  input  logic             pull,
  output logic             fire
);

  logic [CNT_W-1:0] cd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             held_q;

  assign fire = held_q && (cnt_q == '0) && !pull;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_q   <= '0;
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      if (cd_we) cd_q <= cd_val;
      if (arm) begin
        held_q <= 1'b1;
        cnt_q  <= cd_q;
      end else if (pull) begin
        held_q <= 1'b0;
      end else if (held_q) begin
        if (cnt_q == '0) held_q <= 1'b0;
        else             cnt_q  <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R7: a held slot counts down by one each cycle
  p_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && cnt_q != '0 && !arm && !pull) |=> (held_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R8: a retract empties the slot
  p_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && !arm) |=> (!held_q && !fire));
  // R10: arming (also re-arming) loads the countdown register
  p_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (held_q && cnt_q == $past(cd_q)));

endmodule

// File: rtl/fipi_pend_bank.sv
module fipi_pend_bank #(
  parameter int unsigned NCORE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] set_v,
  input  logic [NCORE-1:0] wake_v,
  input  logic [NCORE-1:0] clr_v,
  output logic [NCORE-1:0] pend,
  output logic [NCORE-1:0] wake_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      wake_q <= '0;
    end else begin
      pend   <= (pend & ~clr_v) | set_v;
      wake_q <= wake_v;
    end
  end

  // R6: a set lands even when a clear arrives together
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((pend & $past(set_v)) == $past(set_v)));
  // R6: a lone clear drops the bit
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_v & ~set_v) != '0) |=> ((pend & $past(clr_v & ~set_v)) == '0));
  // R6: no set and no clear keeps the level
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v == '0 && clr_v == '0) |=> $stable(pend));
  // R4: a wake pulse always comes with the level
  p_wake_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_q & ~pend) == '0));

endmodule

// File: rtl/fipi_requester.sv
module fipi_requester #(
  parameter int unsigned NCL   = 2,
  parameter int unsigned NCPC  = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned NCORE = NCL * NCPC,
  localparam int unsigned SRC_W = $clog2(NCORE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SRC_W-1:0] req_src,
  input  logic             req_global,
  input  logic [31:0]      req_word,
  input  logic             clr_valid,
  input  logic [SRC_W-1:0] clr_core,
  input  logic [31:0]      clr_word,
  input  logic             cd_wr,
  input  logic [SRC_W-1:0] cd_core,
  input  logic [CNT_W-1:0] cd_value,
  output logic [NCORE-1:0] fiq,
  output logic [NCORE-1:0] wake
);

  logic [NCORE-1:0] hit_now, hit_pull, hit_later, hit_quiet;
  logic [NCORE-1:0] fire, clr_v, set_v, wake_v;

  assign req_ready = 1'b1;

  fipi_decode #(.NCL(NCL), .NCPC(NCPC), .NCORE(NCORE), .SRC_W(SRC_W)) u_decode (
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_global(req_global),
    .req_word  (req_word),
    .hit_now   (hit_now),
    .hit_pull  (hit_pull),
    .hit_later (hit_later),
    .hit_quiet (hit_quiet)
  );

  for (genvar i = 0; i < NCORE; i++) begin : g_slot
    assign clr_v[i] = clr_valid && (clr_core == SRC_W'(i)) && clr_word[0];

    fipi_defer_slot #(.CNT_W(CNT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .cd_we (cd_wr && (cd_core == SRC_W'(i))),
      .cd_val(cd_value),
      .arm   (hit_later[i]),
      .pull  (hit_pull[i]),
      .fire  (fire[i])
    );
  end

  assign set_v  = hit_now | hit_quiet | fire;
  assign wake_v = hit_now | fire;

  fipi_pend_bank #(.NCORE(NCORE)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (set_v),
    .wake_v(wake_v),
    .clr_v (clr_v),
    .pend  (fiq),
    .wake_q(wake)
  );

  logic [NCORE-1:0] any_hit;
  assign any_hit = hit_now | hit_pull | hit_later | hit_quiet;

  // R9: a core field beyond the cluster size reaches nothing
  p_range_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(req_word[7:0]) >= NCPC) |-> (any_hit == '0));
  // R9: a global cluster field beyond the cluster count reaches nothing
  p_range_cl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_global && 32'(req_word[23:16]) >= NCL) |-> (any_hit == '0));
  // R4: immediate sets level and wake on the next cycle
  p_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_now != '0) |=> ((fiq & wake & $past(hit_now)) == $past(hit_now)));
  // R5: a lone no-wake delivery raises the level without a wake pulse
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_quiet != '0 && fire == '0) |=> (((fiq & $past(hit_quiet)) == $past(hit_quiet)) && ((wake & $past(hit_quiet)) == '0)));

endmodule

// File: tb/tb_fipi_requester.sv
`timescale 1ns/1ps
module tb_fipi_requester;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_global;
  logic [2:0]  req_src;
  logic [31:0] req_word;
  logic        clr_valid;
  logic [2:0]  clr_core;
  logic [31:0] clr_word;
  logic        cd_wr;
  logic [2:0]  cd_core;
  logic [15:0] cd_value;
  logic [7:0]  fiq, wake;

  fipi_requester dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_global(req_global), .req_word(req_word),
    .clr_valid(clr_valid), .clr_core(clr_core), .clr_word(clr_word),
    .cd_wr(cd_wr), .cd_core(cd_core), .cd_value(cd_value),
    .fiq(fiq), .wake(wake)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // expected state, derived from the requirements
  bit [7:0] m_fiq, m_wake, m_held;
  int       m_cnt [8];
  int       m_cd  [8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input int cl, input int core, input int kind);
    return {2'b00, 2'(kind), 4'h0, 8'(cl), 8'h00, 8'(core)};
  endfunction

  task automatic model_step();
    int  core, cl, kind, tgt;
    bit  ok, hit, fire, setb, clrb;
    core = int'(req_word[7:0]);
    cl   = req_global ? int'(req_word[23:16]) : int'(req_src) / 4;
    kind = int'(req_word[29:28]);
    ok   = req_valid && core < 4 && cl < 2;
    tgt  = cl * 4 + core;
    for (int i = 0; i < 8; i++) begin
      hit  = ok && tgt == i;
      fire = m_held[i] && m_cnt[i] == 0 && !(hit && kind == 1);
      if (hit && kind == 2) begin m_held[i] = 1; m_cnt[i] = m_cd[i]; end
      else if (hit && kind == 1) m_held[i] = 0;
      else if (m_held[i]) begin
        if (m_cnt[i] == 0) m_held[i] = 0; else m_cnt[i]--;
      end
      setb = (hit && (kind == 0 || kind == 3)) || fire;
      clrb = clr_valid && int'(clr_core) == i && clr_word[0];
      if (setb) m_fiq[i] = 1; else if (clrb) m_fiq[i] = 0;
      m_wake[i] = (hit && kind == 0) || fire;
      if (cd_wr && int'(cd_core) == i) m_cd[i] = int'(cd_value);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(fiq == m_fiq, "R4 R5 R7 fiq vs expected", 32'(fiq), 32'(m_fiq));
    chk(wake == m_wake, "R4 R5 wake vs expected", 32'(wake), 32'(m_wake));
    chk(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'd1);
  endtask

  task automatic idle_in();
    req_valid = 0; req_src = 0; req_global = 0; req_word = 0;
    clr_valid = 0; clr_core = 0; clr_word = 0;
    cd_wr = 0; cd_core = 0; cd_value = 0;
  endtask

  task automatic send(input bit g, input int src, input int cl, input int core, input int kind);
    req_valid = 1; req_global = g; req_src = 3'(src); req_word = mkword(cl, core, kind);
    cycle();
    req_valid = 0;
  endtask

  task automatic do_clr(input int core, input logic [31:0] w);
    clr_valid = 1; clr_core = 3'(core); clr_word = w;
    cycle();
    clr_valid = 0;
  endtask

  task automatic set_cd(input int core, input int v);
    cd_wr = 1; cd_core = 3'(core); cd_value = 16'(v);
    cycle();
    cd_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1..R11 act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    rst_n = 0;
    m_fiq = 0; m_wake = 0; m_held = 0;
    for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_cd[i] = 0; end
    repeat (3) @(negedge clk);
    chk(fiq == 0 && wake == 0, "R1 in reset", {fiq, wake}, 32'd0);
    rst_n = 1;
    cycle();
    chk(fiq == 0 && wake == 0, "R1 after reset", {fiq, wake}, 32'd0);

    // R2 R4: global immediate to cluster 1 core 2
    send(1, 0, 1, 2, 0);
    chk(fiq == 8'h40, "R2 target index", 32'(fiq), 32'h40);
    chk(wake == 8'h40, "R4 wake pulse", 32'(wake), 32'h40);
    cycle();
    chk(fiq == 8'h40 && wake == 0, "R4 level held, pulse ends", {fiq, wake}, 32'h4000);

    // R6: bit 0 clear decides
    do_clr(6, 32'hFFFF_FFFE);
    chk(fiq == 8'h40, "R6 bit0=0 ignored", 32'(fiq), 32'h40);
    do_clr(6, 32'h1);
    chk(fiq == 8'h00, "R6 clear", 32'(fiq), 32'h0);

    // R3: local from core 5 (cluster 1), cluster field 0 ignored
    send(0, 5, 0, 1, 0);
    chk(fiq == 8'h20, "R3 local cluster", 32'(fiq), 32'h20);
    do_clr(5, 32'h1);

    // R5: no-wake
    send(1, 3, 0, 0, 3);
    chk(fiq == 8'h01 && wake == 0, "R5 no-wake", {fiq, wake}, 32'h0100);
    do_clr(0, 32'h1);

    // R6: set beats clear in the same cycle
    clr_valid = 1; clr_core = 2; clr_word = 1;
    send(1, 0, 0, 2, 0);
    clr_valid = 0;
    chk(fiq == 8'h04, "R6 set wins", 32'(fiq), 32'h04);
    do_clr(2, 32'h1);

    // R7: deferred with countdown 4 lands 5 cycles after acceptance
    set_cd(3, 4);
    send(1, 0, 0, 3, 2);
    repeat (4) cycle();
    chk(fiq == 8'h00, "R7 not yet", 32'(fiq), 32'h0);
    cycle();
    chk(fiq == 8'h08 && wake == 8'h08, "R7 delivered", {fiq, wake}, 32'h0808);
    do_clr(3, 32'h1);

    // R10: re-arm restarts the count
    set_cd(3, 3);
    send(1, 0, 0, 3, 2);
    cycle();
    send(1, 1, 0, 3, 2);
    repeat (3) cycle();
    chk(fiq == 8'h00, "R10 restarted", 32'(fiq), 32'h0);
    cycle();
    chk(fiq == 8'h08, "R10 delivered", 32'(fiq), 32'h08);
    do_clr(3, 32'h1);

    // R8: retract held request, then retract against pending
    send(1, 0, 0, 3, 2);
    cycle();
    send(0, 2, 0, 3, 1);
    repeat (8) cycle();
    chk(fiq == 8'h00, "R8 retract cancels", 32'(fiq), 32'h0);
    send(1, 0, 0, 3, 0);
    send(1, 0, 0, 3, 1);
    chk(fiq == 8'h08, "R8 pending untouched", 32'(fiq), 32'h08);
    do_clr(3, 32'h1);

    // R9: out of range
    send(1, 0, 0, 4, 0);
    chk(fiq == 8'h00, "R9 core 4", 32'(fiq), 32'h0);
    send(1, 0, 2, 1, 0);
    chk(fiq == 8'h00, "R9 cluster 2", 32'(fiq), 32'h0);
    send(0, 7, 0, 5, 3);
    chk(fiq == 8'h00, "R9 local core 5", 32'(fiq), 32'h0);

    // random mix against the expected model
    void'($urandom(32'd4242));
    for (int n = 0; n < 4000; n++) begin
      req_valid  = ($urandom % 3) == 0;
      req_src    = 3'($urandom % 8);
      req_global = 1'($urandom % 2);
      req_word   = mkword($urandom % 3, $urandom % 6, $urandom % 4) | ($urandom & 32'hC0F0_FF00);
      clr_valid  = ($urandom % 4) == 0;
      clr_core   = 3'($urandom % 8);
      clr_word   = $urandom;
      cd_wr      = ($urandom % 5) == 0;
      cd_core    = 3'($urandom % 8);
      cd_value   = 16'($urandom % 8);
      cycle();
    end
    idle_in();
    cycle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule